// File: doc/BRIEF.md
# Power Mode Sequencer

This block decides when a small processor core runs, dozes or sleeps deeply. It has three modes. In run, every clock is on. In idle, the core clock stops but peripheral clocks keep going. In power-down, the oscillator itself is switched off.

Software writes one of two request strobes. The block then gates the core clock, the peripheral clock and the oscillator enable to match the mode. It also drives override levels for the address latch strobe, the program fetch strobe, the port 0 float control and the port 2 address select. These levels depend on the mode and on whether code is fetched from internal or external program memory.

Idle and power-down have different wake sources. Power-down can only be left through an enabled external interrupt pin that is configured as level-sensitive. A low level on that pin restarts the oscillator. A counter then waits out a parameterised stabilisation time. The release of the pin to high completes the exit. A hardware reset always returns the block to run. A power-on flag records a cold start, and software can set or clear it.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `por_n_i` or `rst_n_i` is low, the block is in run: `cpu_clk_en_o`, `per_clk_en_o` and `osc_en_o` are 1, `idle_req_o` and `pd_req_o` are 0, and `pin_ovr_o`, `p0_float_o` and `p2_addr_o` are 0.
- R2: A one-cycle `idle_wr_i` pulse in run sets `idle_req_o` at the next edge. At the edge after that the block enters idle, with `cpu_clk_en_o`=0, `per_clk_en_o`=1 and `osc_en_o`=1.
- R3: Idle ends at the first edge where either of these holds: (a) `irq_i & irq_en_i` is nonzero; (b) an enabled external pin (`ext_en_i`=1) is active. A pin is active when it is low if `ext_lvl_i`=1, and on a falling edge between two clock edges if `ext_lvl_i`=0. After that edge the block is in run and both request bits are 0. Interrupt lines that are not enabled have no effect.
- R4: A `pd_req_o` bit in run enters power-down at the next edge, with all three clock enables at 0. If both request bits are set, power-down wins.
- R5: In power-down, interrupt lines and edge-configured pins do not restart the oscillator. Only an enabled pin with `ext_lvl_i`=1 that is low restarts it.
- R6: After a power-down wake, `osc_en_o` is 1 while the clocks stay gated for STAB_CYCLES clock cycles. If every level wake pin goes high before the count ends, the oscillator is switched off again and the block stays in power-down.
- R7: Once the count has ended, the first edge at which no level wake pin is low returns the block to run with both request bits cleared.
- R8: `pin_ovr_o` is 1 outside run. `ale_lvl_o` and `psen_lvl_o` are 1 in idle and 0 throughout power-down.
- R9: In idle and in power-down, `p0_float_o` equals `ext_prog_i`. `p2_addr_o` is 1 only in idle with `ext_prog_i`=1.
- R10: `pof_o` is set while `por_n_i` is low. `rst_n_i` does not change it. A `pof_wr_i` pulse loads `pof_wdata_i` at the next edge.
- R11: `idle_wr_i` and `pd_wr_i` are ignored outside run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | free-running reference clock |
| por_n_i | input | 1 | power-on reset, active low, asynchronous |
| rst_n_i | input | 1 | hardware reset, active low, asynchronous |
| idle_wr_i | input | 1 | software strobe requesting idle |
| pd_wr_i | input | 1 | software strobe requesting power-down |
| pof_wr_i | input | 1 | software write strobe for the power-on flag |
| pof_wdata_i | input | 1 | value written to the power-on flag |
| irq_i | input | N_IRQ | interrupt request lines |
| irq_en_i | input | N_IRQ | interrupt enables |
| ext_pin_n_i | input | N_EXT | external interrupt pins, active low |
| ext_en_i | input | N_EXT | external interrupt enables |
| ext_lvl_i | input | N_EXT | 1 = level-sensitive, 0 = falling edge |
| ext_prog_i | input | 1 | 1 = program memory is external |
| cpu_clk_en_o | output | 1 | core clock gate enable |
| per_clk_en_o | output | 1 | peripheral clock gate enable |
| osc_en_o | output | 1 | oscillator enable |
| idle_req_o | output | 1 | pending or active idle request bit |
| pd_req_o | output | 1 | pending or active power-down request bit |
| pin_ovr_o | output | 1 | pin overrides are in force |
| ale_lvl_o | output | 1 | forced address latch strobe level |
| psen_lvl_o | output | 1 | forced program fetch strobe level |
| p0_float_o | output | 1 | port 0 floats |
| p2_addr_o | output | 1 | port 2 carries address |
| pof_o | output | 1 | power-on flag |

## Verification
The bench builds the block with STAB_CYCLES=5, N_IRQ=4 and N_EXT=2. A short stabilisation window lets one run reach several paths: an aborted power-down wake that releases its pin after two cycles, and a full wake that holds its pin for longer. Two pins allow one to be configured for edges and the other for levels at the same time. This shows that power-down rejects the edge pin while idle accepts it. Four interrupt lines allow disabled and enabled requests to be mixed in a single cycle.

// File: rtl/pms_pkg.sv
package pms_pkg;
   typedef enum logic [2:0] {
      PMS_RUN      = 3'd0,
      PMS_IDLE     = 3'd1,
      PMS_PD_SLEEP = 3'd2,
      PMS_PD_WARM  = 3'd3,
      PMS_PD_HOLD  = 3'd4
   } pms_state_e;

   function automatic logic pms_is_pd(pms_state_e s);
      return (s == PMS_PD_SLEEP) || (s == PMS_PD_WARM) || (s == PMS_PD_HOLD);
   endfunction
endpackage

// File: rtl/pms_req_bits.sv
module pms_req_bits (
   input  logic clk_i,
   input  logic rst_n,
   input  logic in_run_i,
   input  logic idle_wr_i,
   input  logic pd_wr_i,
   input  logic wake_i,
   output logic idle_req_o,
   output logic pd_req_o
);
   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
         idle_req_o <= 1'b0;
         pd_req_o   <= 1'b0;
      end else if (wake_i) begin
         idle_req_o <= 1'b0;
         pd_req_o   <= 1'b0;
      end else if (in_run_i) begin
         if (idle_wr_i) idle_req_o <= 1'b1;
         if (pd_wr_i)   pd_req_o   <= 1'b1;
      end
   end

   // R11
   no_idle_set_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!in_run_i && !idle_req_o) |=> !idle_req_o);
   // R11
   no_pd_set_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!in_run_i && !pd_req_o) |=> !pd_req_o);
endmodule

// File: rtl/pms_wake_decode.sv
module pms_wake_decode #(
   parameter int N_IRQ        = 8,
   parameter int N_EXT        = 2,
   parameter bit EDGE_IN_IDLE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_i,
   input  logic [N_IRQ-1:0] irq_en_i,
   input  logic [N_EXT-1:0] pin_n_i,
   input  logic [N_EXT-1:0] ext_en_i,
   input  logic [N_EXT-1:0] ext_lvl_i,
   output logic             idle_wake_o,
   output logic             pd_wake_o
);
   logic [N_EXT-1:0] prev_q;
   logic [N_EXT-1:0] lvl_act;
   logic [N_EXT-1:0] edge_act;
   logic             edge_any;

   for (genvar g = 0; g < N_EXT; g++) begin : g_pin
      always_ff @(posedge clk_i or negedge rst_n) begin
         if (!rst_n) prev_q[g] <= 1'b1;
         else        prev_q[g] <= pin_n_i[g];
      end
      assign lvl_act[g]  = ext_en_i[g] &  ext_lvl_i[g] & ~pin_n_i[g];
      assign edge_act[g] = ext_en_i[g] & ~ext_lvl_i[g] & prev_q[g] & ~pin_n_i[g];
   end

   if (EDGE_IN_IDLE) begin : g_edge_on
      assign edge_any = |edge_act;
   end else begin : g_edge_off
      assign edge_any = 1'b0;
   end

   assign pd_wake_o   = |lvl_act;
   assign idle_wake_o = (|(irq_i & irq_en_i)) | pd_wake_o | edge_any;

   // R5
   pd_wake_needs_level_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      pd_wake_o |-> (|(ext_lvl_i & ext_en_i & ~pin_n_i)));
endmodule

// File: rtl/pms_stab_timer.sv
module pms_stab_timer #(
   parameter int STAB_CYCLES = 1024
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

   if (STAB_CYCLES < 1) begin : g_bad_stab
      $error("STAB_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (!run_i)      cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = run_i && (cnt_q == LAST);

   // R6
   stab_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      cnt_q <= LAST);
   // R6
   stab_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/pms_pin_ovr.sv
module pms_pin_ovr
   import pms_pkg::*;
(
   input  pms_state_e state_i,
   input  logic       ext_prog_i,
   output logic       pin_ovr_o,
   output logic       ale_lvl_o,
   output logic       psen_lvl_o,
   output logic       p0_float_o,
   output logic       p2_addr_o
);
   logic in_idle;
   logic in_pd;

   assign in_idle = (state_i == PMS_IDLE);
   assign in_pd   = pms_is_pd(state_i);

   always_comb begin
      pin_ovr_o  = in_idle | in_pd;
      ale_lvl_o  = in_idle;
      psen_lvl_o = in_idle;
      p0_float_o = pin_ovr_o & ext_prog_i;
      p2_addr_o  = in_idle & ext_prog_i;
   end

   // R9
   always_comb begin
      p2_addr_float_chk: assert (!p2_addr_o || p0_float_o);
   end
endmodule

// File: rtl/pms_pof.sv
module pms_pof (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic wr_i,
   input  logic wdata_i,
   output logic pof_o
);
   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)  pof_o <= 1'b1;
      else if (wr_i) pof_o <= wdata_i;
   end

   // R10
   pof_hold_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !wr_i |=> $stable(pof_o));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pms_pkg::*;
#(
   parameter int STAB_CYCLES  = 1024,
   parameter int N_IRQ        = 8,
   parameter int N_EXT        = 2,
   parameter bit EDGE_IN_IDLE = 1'b1
) (
   input  logic             clk_i,
   input  logic             por_n_i,
   input  logic             rst_n_i,
   input  logic             idle_wr_i,
   input  logic             pd_wr_i,
   input  logic             pof_wr_i,
   input  logic             pof_wdata_i,
   input  logic [N_IRQ-1:0] irq_i,
   input  logic [N_IRQ-1:0] irq_en_i,
   input  logic [N_EXT-1:0] ext_pin_n_i,
   input  logic [N_EXT-1:0] ext_en_i,
   input  logic [N_EXT-1:0] ext_lvl_i,
   input  logic             ext_prog_i,
   output logic             cpu_clk_en_o,
   output logic             per_clk_en_o,
   output logic             osc_en_o,
   output logic             idle_req_o,
   output logic             pd_req_o,
   output logic             pin_ovr_o,
   output logic             ale_lvl_o,
   output logic             psen_lvl_o,
   output logic             p0_float_o,
   output logic             p2_addr_o,
   output logic             pof_o
);
   if (N_IRQ < 1 || N_EXT < 1) begin : g_bad_width
      $error("N_IRQ and N_EXT must be at least 1");
   end

   logic       rst_n;
   pms_state_e state_q, state_d;
   logic       idle_wake, pd_wake, stab_done, wake_done;

   assign rst_n = por_n_i & rst_n_i;

   pms_wake_decode #(.N_IRQ(N_IRQ), .N_EXT(N_EXT), .EDGE_IN_IDLE(EDGE_IN_IDLE)) u_wake (
      .clk_i(clk_i), .rst_n(rst_n), .irq_i(irq_i), .irq_en_i(irq_en_i),
      .pin_n_i(ext_pin_n_i), .ext_en_i(ext_en_i), .ext_lvl_i(ext_lvl_i),
      .idle_wake_o(idle_wake), .pd_wake_o(pd_wake));

   pms_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
      .clk_i(clk_i), .rst_n(rst_n), .run_i(state_q == PMS_PD_WARM), .done_o(stab_done));

   pms_req_bits u_req (
      .clk_i(clk_i), .rst_n(rst_n), .in_run_i(state_q == PMS_RUN),
      .idle_wr_i(idle_wr_i), .pd_wr_i(pd_wr_i), .wake_i(wake_done),
      .idle_req_o(idle_req_o), .pd_req_o(pd_req_o));

   pms_pof u_pof (
      .clk_i(clk_i), .por_n_i(por_n_i), .wr_i(pof_wr_i), .wdata_i(pof_wdata_i), .pof_o(pof_o));

   pms_pin_ovr u_pins (
      .state_i(state_q), .ext_prog_i(ext_prog_i), .pin_ovr_o(pin_ovr_o),
      .ale_lvl_o(ale_lvl_o), .psen_lvl_o(psen_lvl_o),
      .p0_float_o(p0_float_o), .p2_addr_o(p2_addr_o));

   always_comb begin
      state_d   = state_q;
      wake_done = 1'b0;
      unique case (state_q)
         PMS_RUN: begin
            if (pd_req_o)        state_d = PMS_PD_SLEEP;
            else if (idle_req_o) state_d = PMS_IDLE;
         end
         PMS_IDLE: begin
            if (idle_wake) begin
               state_d   = PMS_RUN;
               wake_done = 1'b1;
            end
         end
         PMS_PD_SLEEP: begin
            if (pd_wake) state_d = PMS_PD_WARM;
         end
         PMS_PD_WARM: begin
            if (!pd_wake)       state_d = PMS_PD_SLEEP;
            else if (stab_done) state_d = PMS_PD_HOLD;
         end
         PMS_PD_HOLD: begin
            if (!pd_wake) begin
               state_d   = PMS_RUN;
               wake_done = 1'b1;
            end
         end
         default: state_d = PMS_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) state_q <= PMS_RUN;
      else        state_q <= state_d;
   end

   always_comb begin
      cpu_clk_en_o = (state_q == PMS_RUN);
      per_clk_en_o = (state_q == PMS_RUN) || (state_q == PMS_IDLE);
      osc_en_o     = (state_q != PMS_PD_SLEEP);
   end

   // R3
   idle_wake_run_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (state_q == PMS_IDLE && idle_wake) |=> (cpu_clk_en_o && !idle_req_o && !pd_req_o));
   // R4
   pd_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (state_q == PMS_RUN && pd_req_o) |=> !osc_en_o);
   // R5
   pd_stay_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (state_q == PMS_PD_SLEEP && !pd_wake) |=> !osc_en_o);
   // R6
   warm_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (state_q == PMS_PD_WARM && !pd_wake) |=> (state_q == PMS_PD_SLEEP));
   // R7
   hold_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (state_q == PMS_PD_HOLD && !pd_wake) |=> (cpu_clk_en_o && !pd_req_o));
   // R7
   no_early_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (state_q == PMS_PD_WARM) |=> !cpu_clk_en_o);
endmodule

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int STAB  = 5;
   localparam int NIRQ  = 4;
   localparam int NEXT  = 2;

   logic clk = 1'b0;
   logic por_n = 1'b0, rst_n = 1'b1;
   logic idle_wr = 0, pd_wr = 0, pof_wr = 0, pof_wdata = 0;
   logic [NIRQ-1:0] irq = '0, irq_en = '0;
   logic [NEXT-1:0] pin_n = '1, ext_en = '0, ext_lvl = '0;
   logic ext_prog = 1'b0;
   logic cpu_en, per_en, osc_en, idle_req, pd_req, pin_ovr, ale, psen, p0f, p2a, pof;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_seq #(.STAB_CYCLES(STAB), .N_IRQ(NIRQ), .N_EXT(NEXT)) dut_i (
      .clk_i(clk), .por_n_i(por_n), .rst_n_i(rst_n), .idle_wr_i(idle_wr), .pd_wr_i(pd_wr),
      .pof_wr_i(pof_wr), .pof_wdata_i(pof_wdata), .irq_i(irq), .irq_en_i(irq_en),
      .ext_pin_n_i(pin_n), .ext_en_i(ext_en), .ext_lvl_i(ext_lvl), .ext_prog_i(ext_prog),
      .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en),
      .idle_req_o(idle_req), .pd_req_o(pd_req), .pin_ovr_o(pin_ovr), .ale_lvl_o(ale),
      .psen_lvl_o(psen), .p0_float_o(p0f), .p2_addr_o(p2a), .pof_o(pof));

   int n_cmp = 0, n_bad = 0;
   string tag = "R1";
   bit cmp_en = 0;

   // reference model: 0 run, 1 idle, 2 asleep, 3 warming, 4 holding
   int  m_st = 0, m_cnt = 0;
   bit  m_idle = 0, m_pd = 0, m_pof = 1;
   bit  m_prev [NEXT];
   wire rstc = por_n & rst_n;

   always @(posedge clk or negedge rstc) begin
      if (!rstc) begin
         m_st = 0; m_cnt = 0; m_idle = 0; m_pd = 0;
         foreach (m_prev[i]) m_prev[i] = 1;
      end else begin
         bit lvl, edg, irqw, wake;
         int nx;
         lvl = 0; edg = 0; irqw = 0; wake = 0;
         for (int i = 0; i < NEXT; i++) begin
            if (ext_en[i] && ext_lvl[i] && !pin_n[i]) lvl = 1;
            if (ext_en[i] && !ext_lvl[i] && m_prev[i] && !pin_n[i]) edg = 1;
         end
         for (int i = 0; i < NIRQ; i++) if (irq[i] && irq_en[i]) irqw = 1;
         nx = m_st;
         case (m_st)
            0: if (m_pd) nx = 2; else if (m_idle) nx = 1;
            1: if (irqw || lvl || edg) begin nx = 0; wake = 1; end
            2: if (lvl) begin nx = 3; m_cnt = 0; end
            3: if (!lvl) nx = 2;
               else if (m_cnt == STAB-1) nx = 4;
               else m_cnt++;
            default: if (!lvl) begin nx = 0; wake = 1; end
         endcase
         if (m_st == 0) begin
            if (idle_wr) m_idle = 1;
            if (pd_wr)   m_pd = 1;
         end
         if (wake) begin m_idle = 0; m_pd = 0; end
         m_st = nx;
         for (int i = 0; i < NEXT; i++) m_prev[i] = pin_n[i];
      end
   end

   always @(posedge clk or negedge por_n) begin
      if (!por_n) m_pof = 1;
      else if (pof_wr) m_pof = pof_wdata;
   end

   task automatic chk(string t, string nm, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", t, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en) begin
         bit idl, pdm;
         idl = (m_st == 1);
         pdm = (m_st >= 2);
         chk(tag, "cpu_clk_en", cpu_en, m_st == 0);
         chk(tag, "per_clk_en", per_en, m_st <= 1);
         chk(tag, "osc_en",     osc_en, m_st != 2);
         chk(tag, "idle_req",   idle_req, m_idle);
         chk(tag, "pd_req",     pd_req, m_pd);
         chk(tag, "pin_ovr",    pin_ovr, idl | pdm);
         chk(tag, "ale_lvl",    ale, idl);
         chk(tag, "psen_lvl",   psen, idl);
         chk(tag, "p0_float",   p0f, (idl | pdm) & ext_prog);
         chk(tag, "p2_addr",    p2a, idl & ext_prog);
         chk(tag, "pof",        pof, m_pof);
      end
   end

   task automatic adv(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic at_neg();
      @(negedge clk); #1;
   endtask

   initial begin
      adv(3);
      por_n = 1; cmp_en = 1;
      adv(1);
      at_neg();
      chk("R1", "cold cpu_clk_en", cpu_en, 1'b1);
      chk("R10", "cold pof", pof, 1'b1);
      adv(1);
      // R10 software clear, then hardware reset keeps it
      tag = "R10"; pof_wr = 1; pof_wdata = 0; adv(1); pof_wr = 0; adv(1);
      rst_n = 0; adv(2); rst_n = 1; adv(1);
      at_neg(); chk("R10", "pof after hw reset", pof, 1'b0);
      adv(1);
      pof_wr = 1; pof_wdata = 1; adv(1); pof_wr = 0; adv(1);

      // R2 idle entry, external program memory
      tag = "R2"; ext_prog = 1; irq_en = 4'b0101;
      idle_wr = 1; adv(1); idle_wr = 0; adv(1);
      at_neg();
      chk("R2", "idle cpu_clk_en", cpu_en, 1'b0);
      chk("R2", "idle per_clk_en", per_en, 1'b1);
      chk("R8", "idle ale", ale, 1'b1);
      chk("R9", "idle p2_addr", p2a, 1'b1);
      // R11 power-down request ignored while idle
      tag = "R11"; adv(1); pd_wr = 1; adv(1); pd_wr = 0; adv(1);
      at_neg(); chk("R11", "pd_req in idle", pd_req, 1'b0);
      // R3 disabled interrupt ignored, enabled one wakes
      tag = "R3"; adv(1); irq = 4'b1010; adv(3);
      at_neg(); chk("R3", "disabled irq cpu", cpu_en, 1'b0);
      adv(1); irq = 4'b0100; adv(1); irq = '0; adv(1);
      at_neg(); chk("R3", "irq wake cpu", cpu_en, 1'b1);

      // R3 edge pin wake from idle
      adv(1); ext_en = 2'b01; ext_lvl = 2'b00;
      idle_wr = 1; adv(1); idle_wr = 0; adv(3);
      pin_n = 2'b10; adv(1);
      at_neg(); chk("R3", "edge wake cpu", cpu_en, 1'b1);
      adv(1); pin_n = 2'b11; adv(2);

      // R4 both requests: power-down wins, internal program memory
      tag = "R4"; ext_prog = 0;
      idle_wr = 1; pd_wr = 1; adv(1); idle_wr = 0; pd_wr = 0; adv(1);
      at_neg();
      chk("R4", "pd osc_en", osc_en, 1'b0);
      chk("R8", "pd ale", ale, 1'b0);
      chk("R9", "pd p0_float", p0f, 1'b0);
      // R5 enabled irq and edge pin ignored in power-down
      tag = "R5"; adv(1); irq = 4'b0001; adv(2); irq = '0;
      pin_n = 2'b10; adv(2); pin_n = 2'b11; adv(2);
      ext_prog = 1; adv(1);
      at_neg(); chk("R5", "pd still asleep", osc_en, 1'b0);
      chk("R9", "pd ext p0_float", p0f, 1'b1);
      chk("R9", "pd ext p2_addr", p2a, 1'b0);
      // R6 short pulse on level pin aborts wake
      tag = "R6"; adv(1); ext_en = 2'b11; ext_lvl = 2'b10;
      pin_n = 2'b01; adv(1);
      at_neg(); chk("R6", "warm osc_en", osc_en, 1'b1);
      chk("R6", "warm cpu", cpu_en, 1'b0);
      adv(1); pin_n = 2'b11; adv(1);
      at_neg(); chk("R6", "abort osc_en", osc_en, 1'b0);
      // R7 full wake
      tag = "R7"; adv(1); pin_n = 2'b01; adv(STAB + 3);
      at_neg(); chk("R7", "hold cpu", cpu_en, 1'b0);
      adv(1); pin_n = 2'b11; adv(1);
      at_neg(); chk("R7", "wake cpu", cpu_en, 1'b1);
      chk("R7", "wake pd_req", pd_req, 1'b0);

      // R1 hardware reset during idle
      tag = "R1"; adv(1); idle_wr = 1; adv(1); idle_wr = 0; adv(3);
      rst_n = 0; adv(1);
      at_neg(); chk("R1", "reset cpu", cpu_en, 1'b1);
      chk("R1", "reset idle_req", idle_req, 1'b0);
      adv(1); rst_n = 1; adv(3);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_bad++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule